// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Port with Address Filtering

This block is a full-duplex asynchronous serial port controlled through a small byte-wide register port. A two-bit mode field selects an 8-bit character format, one of two equivalent 9-bit character formats, or a reserved code in which the port is idle. In the 9-bit formats the extra bit sent is taken from a control bit. The extra bit received is kept in a status bit. In the 8-bit format that status bit holds the received stop bit instead.

Bit timing comes from an external enable pulse, `baud_tick`. Each bit period is `OVS` qualified ticks long. A speed bit selects whether every tick counts or only every second one, so setting it doubles the line rate. The receiver takes three samples around mid-bit and uses the majority value. It drops a start bit that has gone high again by mid-bit.

An address filter serves multidrop links. When it is enabled in a 9-bit mode, only frames whose ninth bit is 1 reach software. In the 8-bit mode, only frames with a valid stop bit reach software. The transmit-complete and receive-complete flags are set by hardware. Software clears them by writing 0 to their bit positions, and writing 1 to a flag bit has no effect.

Top module: `mpuart`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the speed register (address 2) reads 0x00, the receive buffer (address 1) reads 0x00, and `txd` is 1.
- R2: With mode field 00 (control bits 7:6), a write to address 1 sends nothing: `txd` stays 1 and the transmit flag (control bit 1) stays 0. A frame arriving on `rxd` in mode 00 does not set the receive flag (control bit 0).
- R3: In modes 01, 10 and 11, a write to address 1 sends one frame on `txd`. The frame is a 0 start bit, then the eight data bits least significant bit first, then (in modes 10 and 11 only) control bit 3 as the ninth bit, then a 1 stop bit.
- R4: The transmit flag, control bit 1, becomes 1 once the stop bit of a transmitted frame has been sent.
- R5: Only a control write clears either flag, and it clears only the flags whose written bit is 0. Writing 1 to bit 1 or bit 0 leaves that flag unchanged. Writes to control bit 2 are ignored.
- R6: In mode 01 with the address filter (control bit 5) off, a received frame updates the receive buffer, copies its stop bit into control bit 2, and sets the receive flag. This holds even when the stop bit is 0.
- R7: In modes 10 and 11 with the address filter off, a received frame updates the receive buffer, copies its ninth bit into control bit 2, and sets the receive flag.
- R8: The receiver runs only while the receive enable (control bit 4) is 1. A frame sent while it is 0 leaves the buffer, control bit 2 and the receive flag unchanged.
- R9: In modes 10 and 11 with the address filter on, a frame whose ninth bit is 0 leaves the buffer, control bit 2 and the receive flag unchanged. A frame whose ninth bit is 1 is accepted as in R7.
- R10: In mode 01 with the address filter on, a frame whose stop bit is 0 is dropped as in R9, and a frame whose stop bit is 1 is accepted as in R6.
- R11: With speed bit 0 (address 2, bit 0) set, one bit lasts `OVS` ticks of `baud_tick`. With it clear, one bit lasts `2*OVS` ticks, in both directions.
- R12: A low pulse on `rxd` shorter than half a bit period is not taken as a start bit and sets no flag.
- R13: Whenever no frame is being sent, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | Oversampling enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 data, 2 speed |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |

## Verification
The bench builds the block with `OVS` = 8 and `DW` = 8, and holds `baud_tick` high on every cycle. A bit therefore lasts 8 clocks with the speed bit set and 16 clocks with it clear. Short bit periods let every mode, filter case, stop-bit value and both speeds be covered by full frames within a few thousand cycles. With `OVS` = 8, a two-clock glitch ends before the three mid-bit samples are taken, so start-bit rejection can be checked exactly.

// File: rtl/mpuart_pkg.sv
// Package: shared mode codes, receiver states and register addresses.
// Assumes: the register port is at least eight bits wide.
package mpuart_pkg;
    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_8    = 2'b01,
        MODE_9A   = 2'b10,
        MODE_9B   = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_NINTH,
        RX_STOP
    } rx_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_AUX  = 2'd2;

    // Control register bit positions
    localparam int B_MODE_HI = 7;
    localparam int B_MODE_LO = 6;
    localparam int B_MP      = 5;
    localparam int B_RXEN    = 4;
    localparam int B_TX9     = 3;
    localparam int B_RX9     = 2;
    localparam int B_TXFL    = 1;
    localparam int B_RXFL    = 0;
endpackage

// File: rtl/mpuart_rate.sv
// Module: turns the external tick into the qualified oversampling tick.
// Assumes: with fast set every tick passes; otherwise every second tick passes.
module mpuart_rate (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fast,
    output logic bt
);
    logic half;

    // Toggle a phase bit on each raw tick to drop alternate ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) half <= 1'b0;
        else if (tick) half <= ~half;
    end

    assign bt = tick & (fast | half);
endmodule

// File: rtl/mpuart_tx.sv
// Module: frame transmitter with an optional ninth bit.
// Assumes: load is only honoured while idle; OVS ticks of bt per bit.
module mpuart_tx #(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bt,
    input  logic          load,
    input  logic          ninth_en,
    input  logic          ninth,
    input  logic [DW-1:0] data,
    output logic          txd,
    output logic          busy,
    output logic          done
);
    localparam int CW = $clog2(OVS);
    localparam int FW = DW + 3;
    localparam int NW = $clog2(FW + 1);

    logic [FW-1:0] frame;
    logic [CW-1:0] cnt;
    logic [NW-1:0] bitn;
    logic [NW-1:0] last;

    assign last = ninth_en ? NW'(FW - 1) : NW'(FW - 2);

    // Load a frame, then shift one bit out per OVS qualified ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame <= '1;
            cnt   <= '0;
            bitn  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (load) begin
                    frame <= {1'b1, (ninth_en ? ninth : 1'b1), data, 1'b0};
                    cnt   <= '0;
                    bitn  <= '0;
                    busy  <= 1'b1;
                end
            end else if (bt) begin
                if (cnt == CW'(OVS - 1)) begin
                    cnt   <= '0;
                    frame <= {1'b1, frame[FW-1:1]};
                    if (bitn == last) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bitn <= bitn + 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign txd = busy ? frame[0] : 1'b1;
endmodule

// File: rtl/mpuart_rx.sv
// Module: frame receiver with 3-sample majority at mid-bit.
// Assumes: OVS >= 8; en low returns it to idle; done pulses at mid stop bit.
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          bt,
    input  logic          ninth_en,
    input  logic          rxd,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          ninth,
    output logic          stopb
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);

    rx_state_e     state;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [1:0]    samp;
    logic          r1, rxs, maj, mid, endbit;

    // Bring the line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1  <= 1'b1;
            rxs <= 1'b1;
        end else begin
            r1  <= rxd;
            rxs <= r1;
        end
    end

    assign maj    = (samp[0] & samp[1]) | (samp[0] & rxs) | (samp[1] & rxs);
    assign mid    = (cnt == CW'(OVS / 2 + 1));
    assign endbit = (cnt == CW'(OVS - 1));

    // Walk start, data, optional ninth and stop bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            samp  <= 2'b11;
            data  <= '0;
            ninth <= 1'b0;
            stopb <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                state <= RX_IDLE;
            end else if (bt) begin
                if (state == RX_IDLE) begin
                    if (!rxs) begin
                        state <= RX_START;
                        cnt   <= CW'(1);
                    end
                end else begin
                    if (cnt == CW'(OVS / 2 - 1)) samp[0] <= rxs;
                    if (cnt == CW'(OVS / 2))     samp[1] <= rxs;
                    cnt <= endbit ? '0 : cnt + 1'b1;
                    if (mid) begin
                        if (state == RX_START && maj) state <= RX_IDLE;
                        if (state == RX_DATA)  data  <= {maj, data[DW-1:1]};
                        if (state == RX_NINTH) ninth <= maj;
                        if (state == RX_STOP) begin
                            stopb <= maj;
                            done  <= 1'b1;
                            state <= RX_IDLE;
                        end
                    end
                    if (endbit) begin
                        if (state == RX_START) begin
                            state <= RX_DATA;
                            idx   <= '0;
                        end else if (state == RX_DATA) begin
                            if (idx == IW'(DW - 1)) state <= ninth_en ? RX_NINTH : RX_STOP;
                            else idx <= idx + 1'b1;
                        end else if (state == RX_NINTH) begin
                            state <= RX_STOP;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mpuart.sv
// Module: register file and frame acceptance around the serial engines.
// Assumes: DW >= 8; flags set by hardware win over a same-cycle clear.
module mpuart
    import mpuart_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          rxd,
    output logic          txd
);
    mode_e         mode_q;
    logic          mp_q, rxen_q, tx9_q, rx9_q, txfl_q, rxfl_q, fast_q;
    logic [DW-1:0] rbuf_q;
    logic          bt, nine, ctrl_wr, load, tx_busy, tx_done;
    logic          rx_done, rx_ninth, rx_stop, accept;
    logic [DW-1:0] rx_data;

    assign nine    = mode_q[1];
    assign ctrl_wr = wr_en && (addr == ADDR_CTRL);
    assign load    = wr_en && (addr == ADDR_DATA) && (mode_q != MODE_NONE);
    assign accept  = rx_done && (!mp_q || (nine ? rx_ninth : rx_stop));

    mpuart_rate u_rate (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .fast(fast_q), .bt(bt)
    );

    mpuart_tx #(.OVS(OVS), .DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .bt(bt), .load(load), .ninth_en(nine),
        .ninth(tx9_q), .data(wdata), .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    mpuart_rx #(.OVS(OVS), .DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rxen_q && (mode_q != MODE_NONE)), .bt(bt),
        .ninth_en(nine), .rxd(rxd), .done(rx_done), .data(rx_data),
        .ninth(rx_ninth), .stopb(rx_stop)
    );

    // Configuration bits and the speed bit, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NONE;
            mp_q   <= 1'b0;
            rxen_q <= 1'b0;
            tx9_q  <= 1'b0;
            fast_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_CTRL) begin
                mode_q <= mode_e'(wdata[B_MODE_HI:B_MODE_LO]);
                mp_q   <= wdata[B_MP];
                rxen_q <= wdata[B_RXEN];
                tx9_q  <= wdata[B_TX9];
            end
            if (addr == ADDR_AUX) fast_q <= wdata[0];
        end
    end

    // Completion flags: hardware sets, a zero in a control write clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txfl_q <= 1'b0;
            rxfl_q <= 1'b0;
        end else begin
            txfl_q <= tx_done | (txfl_q & ~(ctrl_wr & ~wdata[B_TXFL]));
            rxfl_q <= accept  | (rxfl_q & ~(ctrl_wr & ~wdata[B_RXFL]));
        end
    end

    // Receive buffer and received extra bit, updated on accepted frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf_q <= '0;
            rx9_q  <= 1'b0;
        end else if (accept) begin
            rbuf_q <= rx_data;
            rx9_q  <= nine ? rx_ninth : rx_stop;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            ADDR_CTRL: rdata = DW'({mode_q, mp_q, rxen_q, tx9_q, rx9_q, txfl_q, rxfl_q});
            ADDR_DATA: rdata = rbuf_q;
            ADDR_AUX:  rdata = DW'(fast_q);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/mpuart_chk.sv
// Checker: temporal properties of the serial port, bound to mpuart.
// Assumes: signal names of the bound instance as listed in the bind below.
module mpuart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txd,
    input logic       tx_busy,
    input logic       tx_done,
    input logic       txfl,
    input logic       rxfl,
    input logic       rx_done,
    input logic       rx_ninth,
    input logic       rxen,
    input logic       mp,
    input logic [1:0] mode,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wdata
);
    a_r13_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    a_r4_txflag_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txfl) |-> $past(tx_done));

    a_r5_txflag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (txfl && !(wr_en && addr == 2'd0 && !wdata[1])) |=> txfl);

    a_r5_rxflag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rxfl && !(wr_en && addr == 2'd0 && !wdata[0])) |=> rxfl);

    a_r8_rx_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxen && !$past(rxen) && !rxfl) |=> !rxfl);

    a_r9_filter_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && mode[1] && mp && !rx_ninth && !rxfl) |=> !rxfl);
endmodule

bind mpuart mpuart_chk u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .tx_done(tx_done),
    .txfl(txfl_q), .rxfl(rxfl_q), .rx_done(rx_done), .rx_ninth(rx_ninth),
    .rxen(rxen_q), .mp(mp_q), .mode(mode_q), .wr_en(wr_en), .addr(addr),
    .wdata(wdata[7:0])
);

// File: tb/sim_mpuart.sv
// Bench: vector table of frames per mode, then directed reset/corner tests.
module sim_mpuart;
    localparam int CLK_PERIOD = 10;
    localparam int OVS = 8;
    localparam int DW  = 8;
    localparam int NV  = 8;
    // {mode[1:0], filter, fast, data[7:0], ninth, stop, accept}
    localparam logic [14:0] VECS [0:NV-1] = '{
        {2'b01, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b1},
        {2'b01, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b1},
        {2'b10, 1'b0, 1'b1, 8'h5A, 1'b1, 1'b1, 1'b1},
        {2'b11, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b1, 1'b1},
        {2'b10, 1'b1, 1'b1, 8'h77, 1'b0, 1'b1, 1'b0},
        {2'b11, 1'b1, 1'b1, 8'h81, 1'b1, 1'b1, 1'b1},
        {2'b01, 1'b1, 1'b1, 8'hF0, 1'b0, 1'b0, 1'b0},
        {2'b01, 1'b1, 1'b0, 8'h2D, 1'b1, 1'b1, 1'b1}
    };

    logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rxd = 1'b1;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] wdata = '0, rdata;
    logic          txd;
    int            total = 0, bad = 0;
    logic [7:0]    prev_data = 8'h00, rd;
    logic          prev_rx9 = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mpuart #(.OVS(OVS), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(1'b1), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic send_rx(input logic [7:0] d, input logic nine, input logic b9,
                           input logic stp, input int per);
        rxd = 1'b0;
        repeat (per) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (per) @(negedge clk);
        end
        if (nine) begin
            rxd = b9;
            repeat (per) @(negedge clk);
        end
        rxd = stp;
        repeat (per) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * per) @(negedge clk);
    endtask

    task automatic grab_tx(input int n, input int per, output logic [10:0] bits);
        bits = '1;
        repeat (per / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            bits[i] = txd;
            repeat (per) @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog (all) actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [10:0] bits, expf;
        logic        line_ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R13: reset state
        reg_rd(2'd0, rd); check("R1 ctrl", rd, 8'h00);
        reg_rd(2'd2, rd); check("R1 speed", rd, 8'h00);
        reg_rd(2'd1, rd); check("R1 data", rd, 8'h00);
        check("R13 idle txd", txd, 1'b1);

        // Vector table: transmit then receive each entry
        for (int v = 0; v < NV; v++) begin
            logic [1:0] m;  logic mp, fast, b9, stp, acc, nine;
            logic [7:0] d;  int per, n;
            {m, mp, fast, d, b9, stp, acc} = VECS[v];
            nine = m[1];
            per  = fast ? OVS : 2 * OVS;
            n    = nine ? 11 : 10;
            reg_wr(2'd2, {7'd0, fast});
            reg_wr(2'd0, {m, mp, 1'b1, b9, 3'b000});
            reg_wr(2'd1, d);
            grab_tx(n, per, bits);
            expf = nine ? {1'b1, b9, d, 1'b0} : {2'b11, d, 1'b0};
            check(fast ? "R3 tx frame" : "R3/R11 tx frame slow", bits, expf);
            reg_rd(2'd0, rd); check("R4 tx flag", rd[1], 1'b1);
            reg_wr(2'd0, {m, mp, 1'b1, b9, 3'b000});
            send_rx(d, nine, b9, stp, per);
            if (acc) begin
                prev_data = d;
                prev_rx9  = nine ? b9 : stp;
            end
            reg_rd(2'd0, rd);
            check(nine ? (mp ? "R9 rx flag" : "R7 rx flag") : (mp ? "R10 rx flag" : "R6 rx flag"),
                  rd[0], acc);
            check(nine ? "R7/R9 rx9" : "R6/R10 rx9", rd[2], prev_rx9);
            reg_rd(2'd1, rd);
            check(fast ? "R6-R10 data" : "R11 rx data slow", rd, prev_data);
        end

        // R2: reserved mode sends and receives nothing
        reg_wr(2'd2, 8'h01);
        reg_wr(2'd0, 8'b00_0_1_0_000);
        reg_wr(2'd1, 8'h55);
        line_ok = 1'b1;
        for (int i = 0; i < 3 * OVS; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) line_ok = 1'b0;
        end
        check("R2 txd quiet", line_ok, 1'b1);
        send_rx(8'h99, 1'b0, 1'b0, 1'b1, OVS);
        reg_rd(2'd0, rd); check("R2 no flags", rd[1:0], 2'b00);

        // R8: receiver disabled
        reg_wr(2'd0, 8'b01_0_0_0_000);
        send_rx(8'h66, 1'b0, 1'b0, 1'b0, OVS);
        reg_rd(2'd0, rd); check("R8 flag/rx9", {rd[2], rd[0]}, {prev_rx9, 1'b0});
        reg_rd(2'd1, rd); check("R8 data kept", rd, prev_data);

        // R12: short glitch is not a start bit
        reg_wr(2'd0, 8'b01_0_1_0_000);
        @(negedge clk); rxd = 1'b0;
        repeat (2) @(negedge clk); rxd = 1'b1;
        repeat (3 * OVS) @(negedge clk);
        reg_rd(2'd0, rd); check("R12 glitch ignored", rd[0], 1'b0);

        // R5: masked clear of completion flags
        reg_wr(2'd1, 8'h12);
        repeat (12 * OVS) @(negedge clk);
        send_rx(8'h34, 1'b0, 1'b0, 1'b1, OVS);
        reg_rd(2'd0, rd); check("R5 both set", rd[1:0], 2'b11);
        reg_wr(2'd0, 8'b01_0_1_0_111);
        reg_rd(2'd0, rd); check("R5 ones ignored", rd[2:0], 3'b111);
        reg_wr(2'd0, 8'b01_0_1_0_010);
        reg_rd(2'd0, rd); check("R5 clear rx only", rd[1:0], 2'b10);
        reg_wr(2'd0, 8'b01_0_1_0_001);
        reg_rd(2'd0, rd); check("R5 clear tx", rd[1:0], 2'b00);
        check("R13 line idle", txd, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule